// File: doc/BRIEF.md
# Network Controller Status Flags and Interrupt Request

This block keeps the event flags of a network controller in one readable byte. Each flag sets on its own event strobe and drops on one specific command strobe. Events include a packet stored, a reset, a write of zero to the station address, the line idle timer expiring, a transmit acknowledge and a transmit completion. The commands are enable receive, enable transmit and clear flags. When a set event and a clearing command occur in the same cycle, the flag ends up set.

A mask register is written through a simple write port. It selects which flags can raise the interrupt request, and the interrupt output is a combinational function of the flag and mask registers. The receiver-inhibit flag also drives a reject output. The receive path uses it to answer an incoming packet with a negative acknowledge while no receive buffer is armed.

Top module: `net_status_irq`

## Requirements
- R1: After reset, status_o reads 8'h91, with bit 7, bit 4 and bit 0 high and all other bits low. The mask reads as zero, irq_o is 0 and reject_o is 1.
- R2: Bit 7 (receiver inhibited) clears in the cycle after cmd_en_rx_i. It sets in the cycle after pkt_stored_i. No other input changes it.
- R3: reject_o is high exactly while bit 7 of status_o is high.
- R4: Bit 4 (reset occurred) sets after sw_reset_i or nodeid_zero_wr_i. It clears only after cmd_clr_flags_i.
- R5: Bit 2 (reconfiguration) sets after idle_expired_i and clears only after cmd_clr_flags_i.
- R6: Bit 1 (transmit acknowledged) sets after tx_ack_i when tx_bcast_i is low. tx_ack_i has no effect when tx_bcast_i is high. The bit clears only after cmd_en_tx_i.
- R7: Bit 0 (transmit done) sets after tx_done_i and clears only after cmd_en_tx_i.
- R8: Bits 6, 5 and 3 of status_o always read 0.
- R9: If a flag's set event and its clearing command arrive in the same cycle, the flag is high in the next cycle.
- R10: irq_o equals (status bit 7 AND mask bit 7) OR (status bit 2 AND mask bit 2), using the mask as stored. A mask write through mask_we_i takes effect in the next cycle. The other mask bits never affect irq_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous hardware reset |
| pkt_stored_i | input | 1 | Packet written into the armed receive page |
| sw_reset_i | input | 1 | Software reset event |
| nodeid_zero_wr_i | input | 1 | Station address register written with zero |
| idle_expired_i | input | 1 | Line idle timer expired |
| tx_ack_i | input | 1 | Transmitted packet acknowledged |
| tx_bcast_i | input | 1 | Current transmission is a broadcast |
| tx_done_i | input | 1 | Transmission finished |
| cmd_en_rx_i | input | 1 | Enable-receive command |
| cmd_en_tx_i | input | 1 | Enable-transmit command |
| cmd_clr_flags_i | input | 1 | Clear-flags command |
| mask_we_i | input | 1 | Mask register write strobe |
| mask_wdata_i | input | 8 | Mask register write data |
| status_o | output | 8 | Status byte |
| irq_o | output | 1 | Interrupt request |
| reject_o | output | 1 | Answer incoming packets with a negative acknowledge |

## Verification
The bench builds the block with its default parameters. The interrupt sources are bits 7 and 2, and transmit done resets high. With these values, the masked interrupt path, the reserved-bit rules and the reset byte 8'h91 can all be observed at the ports. Random strobes with mask writes that cover all eight bits check that unselected mask bits stay inert. Directed same-cycle set/clear pairs exercise the priority rule on every flag.

// File: rtl/net_status_pkg.sv
package net_status_pkg;
   localparam int STAT_W    = 8;
   localparam int RI_BIT    = 7;
   localparam int POR_BIT   = 4;
   localparam int RECON_BIT = 2;
   localparam int TMA_BIT   = 1;
   localparam int TA_BIT    = 0;
   localparam logic [STAT_W-1:0] RSVD_BITS = 8'b0110_1000;
endpackage

// File: rtl/status_flag.sv
module status_flag #(
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q_o <= RST_VAL;
      else if (set_i)  q_o <= 1'b1;
      else if (clr_i)  q_o <= 1'b0;
   end

   p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> q_o);
   p_clear_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i) |=> !q_o);
endmodule

// File: rtl/mask_reg.sv
module mask_reg #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we_i,
   input  logic [W-1:0] wdata_i,
   output logic [W-1:0] q_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q_o <= '0;
      else if (we_i) q_o <= wdata_i;
   end

   p_mask_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !we_i |=> $stable(q_o));
endmodule

// File: rtl/irq_combine.sv
module irq_combine #(
   parameter int W = 8,
   parameter logic [W-1:0] SRC = '0
) (
   input  logic [W-1:0] flags_i,
   input  logic [W-1:0] mask_i,
   output logic         irq_o
);
   logic [W-1:0] term;

   for (genvar i = 0; i < W; i++) begin : g_term
      if (SRC[i]) begin : g_src
         assign term[i] = flags_i[i] & mask_i[i];
      end else begin : g_none
         assign term[i] = 1'b0;
      end
   end

   assign irq_o = |term;
endmodule

// File: rtl/net_status_irq.sv
module net_status_irq
   import net_status_pkg::*;
#(
   parameter logic [7:0] IRQ_SRC = 8'h84,
   parameter logic       TA_RST  = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pkt_stored_i,
   input  logic       sw_reset_i,
   input  logic       nodeid_zero_wr_i,
   input  logic       idle_expired_i,
   input  logic       tx_ack_i,
   input  logic       tx_bcast_i,
   input  logic       tx_done_i,
   input  logic       cmd_en_rx_i,
   input  logic       cmd_en_tx_i,
   input  logic       cmd_clr_flags_i,
   input  logic       mask_we_i,
   input  logic [7:0] mask_wdata_i,
   output logic [7:0] status_o,
   output logic       irq_o,
   output logic       reject_o
);
   localparam logic [STAT_W-1:0] FLAG_RST =
      {1'b1, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0, TA_RST};

   if ((IRQ_SRC & RSVD_BITS) != '0) begin : g_bad_src
      $error("IRQ_SRC selects a reserved status bit");
   end
   if (STAT_W != 8) begin : g_bad_width
      $error("status byte must be 8 bits wide");
   end

   logic [STAT_W-1:0] mask_q;

   for (genvar i = 0; i < STAT_W; i++) begin : g_bit
      if (i == RI_BIT) begin : g_ri
         status_flag #(.RST_VAL(FLAG_RST[i])) u_flag (
            .clk(clk), .rst_n(rst_n),
            .set_i(pkt_stored_i), .clr_i(cmd_en_rx_i), .q_o(status_o[i]));
      end else if (i == POR_BIT) begin : g_por
         status_flag #(.RST_VAL(FLAG_RST[i])) u_flag (
            .clk(clk), .rst_n(rst_n),
            .set_i(sw_reset_i | nodeid_zero_wr_i), .clr_i(cmd_clr_flags_i),
            .q_o(status_o[i]));
      end else if (i == RECON_BIT) begin : g_recon
         status_flag #(.RST_VAL(FLAG_RST[i])) u_flag (
            .clk(clk), .rst_n(rst_n),
            .set_i(idle_expired_i), .clr_i(cmd_clr_flags_i), .q_o(status_o[i]));
      end else if (i == TMA_BIT) begin : g_tma
         status_flag #(.RST_VAL(FLAG_RST[i])) u_flag (
            .clk(clk), .rst_n(rst_n),
            .set_i(tx_ack_i & ~tx_bcast_i), .clr_i(cmd_en_tx_i),
            .q_o(status_o[i]));
      end else if (i == TA_BIT) begin : g_ta
         status_flag #(.RST_VAL(FLAG_RST[i])) u_flag (
            .clk(clk), .rst_n(rst_n),
            .set_i(tx_done_i), .clr_i(cmd_en_tx_i), .q_o(status_o[i]));
      end else begin : g_rsvd
         assign status_o[i] = 1'b0;
      end
   end

   mask_reg #(.W(STAT_W)) u_mask (
      .clk(clk), .rst_n(rst_n), .we_i(mask_we_i),
      .wdata_i(mask_wdata_i), .q_o(mask_q));

   irq_combine #(.W(STAT_W), .SRC(IRQ_SRC)) u_irq (
      .flags_i(status_o), .mask_i(mask_q), .irq_o(irq_o));

   assign reject_o = status_o[RI_BIT];

   p_rx_arm_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_en_rx_i && !pkt_stored_i) |=> !reject_o);
   p_por_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (status_o[POR_BIT] && !cmd_clr_flags_i) |=> status_o[POR_BIT]);
   p_bcast_no_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!status_o[TMA_BIT] && tx_bcast_i) |=> !status_o[TMA_BIT]);
   p_irq_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ((mask_q & IRQ_SRC) == '0) |-> !irq_o);
endmodule

// File: tb/net_status_irq_tb.sv
module net_status_irq_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pkt_stored_i = 0, sw_reset_i = 0, nodeid_zero_wr_i = 0;
   logic       idle_expired_i = 0, tx_ack_i = 0, tx_bcast_i = 0, tx_done_i = 0;
   logic       cmd_en_rx_i = 0, cmd_en_tx_i = 0, cmd_clr_flags_i = 0;
   logic       mask_we_i = 0;
   logic [7:0] mask_wdata_i = 8'h00;
   logic [7:0] status_o;
   logic       irq_o, reject_o;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   // reference state
   bit m_ri, m_por, m_recon, m_tma, m_ta;
   logic [7:0] m_mask;

   always #5 clk = ~clk;

   net_status_irq u_dut (
      .clk(clk), .rst_n(rst_n),
      .pkt_stored_i(pkt_stored_i), .sw_reset_i(sw_reset_i),
      .nodeid_zero_wr_i(nodeid_zero_wr_i), .idle_expired_i(idle_expired_i),
      .tx_ack_i(tx_ack_i), .tx_bcast_i(tx_bcast_i), .tx_done_i(tx_done_i),
      .cmd_en_rx_i(cmd_en_rx_i), .cmd_en_tx_i(cmd_en_tx_i),
      .cmd_clr_flags_i(cmd_clr_flags_i), .mask_we_i(mask_we_i),
      .mask_wdata_i(mask_wdata_i), .status_o(status_o), .irq_o(irq_o),
      .reject_o(reject_o));

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      chk("R2 ri bit7", int'(status_o[7]), int'(m_ri));
      chk("R4 por bit4", int'(status_o[4]), int'(m_por));
      chk("R5 recon bit2", int'(status_o[2]), int'(m_recon));
      chk("R6 tma bit1", int'(status_o[1]), int'(m_tma));
      chk("R7 ta bit0", int'(status_o[0]), int'(m_ta));
      chk("R8 reserved", int'({status_o[6:5], status_o[3]}), 0);
      chk("R3 reject", int'(reject_o), int'(m_ri));
      chk("R10 irq", int'(irq_o),
          int'((m_ri & m_mask[7]) | (m_recon & m_mask[2])));
   endtask

   // apply the driven inputs to the reference for the coming edge
   task automatic model_step();
      if (pkt_stored_i) m_ri = 1; else if (cmd_en_rx_i) m_ri = 0;
      if (sw_reset_i || nodeid_zero_wr_i) m_por = 1;
      else if (cmd_clr_flags_i) m_por = 0;
      if (idle_expired_i) m_recon = 1; else if (cmd_clr_flags_i) m_recon = 0;
      if (tx_ack_i && !tx_bcast_i) m_tma = 1; else if (cmd_en_tx_i) m_tma = 0;
      if (tx_done_i) m_ta = 1; else if (cmd_en_tx_i) m_ta = 0;
      if (mask_we_i) m_mask = mask_wdata_i;
   endtask

   task automatic idle_inputs();
      {pkt_stored_i, sw_reset_i, nodeid_zero_wr_i, idle_expired_i, tx_ack_i,
       tx_bcast_i, tx_done_i, cmd_en_rx_i, cmd_en_tx_i, cmd_clr_flags_i,
       mask_we_i} = '0;
      mask_wdata_i = 8'h00;
   endtask

   task automatic cycle();
      model_step();
      @(negedge clk);
      compare_all();
      idle_inputs();
   endtask

   initial begin
      m_ri = 1; m_por = 1; m_recon = 0; m_tma = 0; m_ta = 1; m_mask = 8'h00;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 status", int'(status_o), 'h91);
      chk("R1 irq", int'(irq_o), 0);
      chk("R1 reject", int'(reject_o), 1);
      rst_n = 1'b1;
      @(negedge clk);
      compare_all();

      // R10: unused mask bits have no effect, selected bit enables irq
      mask_we_i = 1; mask_wdata_i = 8'h7B; cycle();
      chk("R10 inert mask bits", int'(irq_o), 0);
      mask_we_i = 1; mask_wdata_i = 8'h80; cycle();
      chk("R10 ri irq", int'(irq_o), 1);
      // R2/R3: arm receive
      cmd_en_rx_i = 1; cycle();
      chk("R2 armed", int'(status_o[7]), 0);
      chk("R3 armed", int'(reject_o), 0);
      // R9: packet stored and enable receive together
      pkt_stored_i = 1; cmd_en_rx_i = 1; cycle();
      chk("R9 ri set wins", int'(status_o[7]), 1);
      // R4: clear flags, then node id zero write
      cmd_clr_flags_i = 1; cycle();
      chk("R4 por cleared", int'(status_o[4]), 0);
      nodeid_zero_wr_i = 1; cycle();
      chk("R4 por on id zero", int'(status_o[4]), 1);
      sw_reset_i = 1; cmd_clr_flags_i = 1; cycle();
      chk("R9 por set wins", int'(status_o[4]), 1);
      // R5 with irq via bit 2
      mask_we_i = 1; mask_wdata_i = 8'h04; cmd_en_rx_i = 1; cycle();
      idle_expired_i = 1; cycle();
      chk("R5 recon set", int'(status_o[2]), 1);
      chk("R10 recon irq", int'(irq_o), 1);
      // R6/R7
      cmd_en_tx_i = 1; cycle();
      chk("R7 ta cleared", int'(status_o[0]), 0);
      tx_ack_i = 1; tx_bcast_i = 1; tx_done_i = 1; cycle();
      chk("R6 broadcast ignored", int'(status_o[1]), 0);
      chk("R7 ta set", int'(status_o[0]), 1);
      tx_ack_i = 1; cycle();
      chk("R6 ack set", int'(status_o[1]), 1);
      tx_ack_i = 1; cmd_en_tx_i = 1; cycle();
      chk("R9 tma set wins", int'(status_o[1]), 1);
      cmd_en_tx_i = 1; cycle();
      chk("R6 tma cleared", int'(status_o[1]), 0);

      // random phase compared every cycle
      for (int n = 0; n < 3000; n++) begin
         pkt_stored_i     = ($urandom % 8) == 0;
         sw_reset_i       = ($urandom % 16) == 0;
         nodeid_zero_wr_i = ($urandom % 16) == 0;
         idle_expired_i   = ($urandom % 10) == 0;
         tx_ack_i         = ($urandom % 6) == 0;
         tx_bcast_i       = ($urandom % 2) == 0;
         tx_done_i        = ($urandom % 6) == 0;
         cmd_en_rx_i      = ($urandom % 6) == 0;
         cmd_en_tx_i      = ($urandom % 6) == 0;
         cmd_clr_flags_i  = ($urandom % 8) == 0;
         mask_we_i        = ($urandom % 12) == 0;
         mask_wdata_i     = 8'($urandom);
         cycle();
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule